// File: doc/BRIEF.md
# BCD Calendar Clock with Snapshot Registers

This block keeps wall-clock time and calendar date as packed BCD. A free-running internal set of counters moves forward once per second. The second is made by counting `TICKS_PER_SEC` pulses on `tick_i`. The host never reads the counters directly. It reads and writes a second, external copy through a byte-wide bus that decodes the top sixteen addresses of a `2**ADDR_W` byte window. The external copy tracks the counters one cycle behind, unless the host holds it.

The host has three controls. The first is a stop bit in the seconds register that halts the count. The second is a hold bit that freezes the external copy while the counters keep running, so that a multi-byte read stays coherent. The third is a load bit. While the load bit is set, time fields are written into the external copy. Clearing the load bit moves those values into the counters and restarts the sub-second phase. A frequency-test bit in the day register is kept for software and has no other effect.

Top module: `bcd_rtc`

## Requirements
- R1: After reset, reads return seconds 0x80 (clock stopped), minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00 and control 0x00.
- R2: While running, the seconds value advances by one on the `TICKS_PER_SEC`-th tick pulse, and not before. A read shows the new value from the next cycle on.
- R3: Seconds wrap from 59 to 00 and minutes from 59 to 00, each carrying into the next field. Hours wrap from 23 to 00 and carry into the date. Day-of-week steps 01..07 and wraps from 07 to 01 at midnight.
- R4: The date wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and after 28 in month 02 of a non-leap year.
- R5: Any year whose value is a multiple of 4, including 00, has a 29th of February.
- R6: At midnight after 31 December, the month becomes 01. The year steps by one in BCD, and year 99 wraps to 00.
- R7: Bit 7 of the seconds register (offset 0x9) is the stop bit. A 1 halts counting and a 0 resumes it. It may be written at any time and reads back in bit 7.
- R8: Bit 6 of the control register (offset 0x8) is the hold bit. While it is 1, the external copy stays at the count present when the hold was written, and the internal count keeps running. After the bit is cleared, reads show the current count.
- R9: Bit 7 of the control register is the load bit. Time-field writes to offsets 0x9..0xF reach the external copy only while the load bit is 1, and are ignored otherwise. When the bit goes from 1 to 0, the external values enter the counters and the tick count restarts, so that the next second needs a full `TICKS_PER_SEC` ticks.
- R10: Bit 6 of the day register (offset 0xC) is a frequency-test bit. It is writable at any time, reads back, and leaves the day field unchanged.
- R11: Offsets 0x0..0x7 of the top sixteen, and every address outside them, read 0x00 and ignore writes. Data is returned only when `cs_i` is 1 and `we_i` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sub-second tick pulse, one cycle wide |
| cs_i | input | 1 | Bus select |
| we_i | input | 1 | Write strobe, qualified by cs_i |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the external copy |

## Verification
The range and month-length assertions assume that the host only loads legal BCD values through the load bit. An illegal date or digit would be carried into the counters as written. Every vector therefore writes a complete, valid time and date before it clears the load bit. The assertions also assume that `tick_i` is a single-cycle pulse. The stimulus holds each tick high for exactly one clock and applies no ticks while a load is in progress.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam logic [3:0] IX_CTL  = 4'h8;
  localparam logic [3:0] IX_SEC  = 4'h9;
  localparam logic [3:0] IX_MIN  = 4'hA;
  localparam logic [3:0] IX_HR   = 4'hB;
  localparam logic [3:0] IX_DAY  = 4'hC;
  localparam logic [3:0] IX_DATE = 4'hD;
  localparam logic [3:0] IX_MON  = 4'hE;
  localparam logic [3:0] IX_YR   = 4'hF;

  localparam rtc_time_t RESET_TIME = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                       day: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [6:0] bin;
    bin = {3'b0, yr[7:4]} * 7'd10 + {3'b0, yr[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic sec_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign sec_o = tick_i && run_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (tick_i && run_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  AST_PRESC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R2
  AST_PRESC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R9
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      adv_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t cnt_o
);
  rtc_time_t cnt_q, nxt;

  always_comb begin
    nxt = cnt_q;
    if (cnt_q.sec >= 8'h59) begin
      nxt.sec = 8'h00;
      if (cnt_q.min >= 8'h59) begin
        nxt.min = 8'h00;
        if (cnt_q.hr >= 8'h23) begin
          nxt.hr  = 8'h00;
          nxt.day = (cnt_q.day >= 8'h07) ? 8'h01 : bcd_inc(cnt_q.day);
          if (cnt_q.date >= month_len(cnt_q.mon, cnt_q.yr)) begin
            nxt.date = 8'h01;
            if (cnt_q.mon >= 8'h12) begin
              nxt.mon = 8'h01;
              nxt.yr  = (cnt_q.yr >= 8'h99) ? 8'h00 : bcd_inc(cnt_q.yr);
            end else begin
              nxt.mon = bcd_inc(cnt_q.mon);
            end
          end else begin
            nxt.date = bcd_inc(cnt_q.date);
          end
        end else begin
          nxt.hr = bcd_inc(cnt_q.hr);
        end
      end else begin
        nxt.min = bcd_inc(cnt_q.min);
      end
    end else begin
      nxt.sec = bcd_inc(cnt_q.sec);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RESET_TIME;
    else if (load_i) cnt_q <= load_val_i;
    else if (adv_i)  cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;

  AST_TIME_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q.sec <= 8'h59 && cnt_q.min <= 8'h59 && cnt_q.hr <= 8'h23
    && cnt_q.day >= 8'h01 && cnt_q.day <= 8'h07); // R3
  AST_DATE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q.date >= 8'h01 && cnt_q.date <= month_len(cnt_q.mon, cnt_q.yr)); // R4
  AST_MIDNIGHT_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && cnt_q.sec == 8'h59 && cnt_q.min == 8'h59 && cnt_q.hr == 8'h23)
    |=> cnt_q.hr == 8'h00 && cnt_q.day != $past(cnt_q.day)); // R3
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned TICKS_PER_SEC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int unsigned TAG_W = ADDR_W - 4;

  logic       in_win, wr, load, sec_pulse;
  logic [3:0] idx;
  logic       ctl_w_q, ctl_r_q, osc_stop_q, ft_q;
  rtc_time_t  ext_q, cnt;

  assign idx    = addr_i[3:0];
  assign in_win = (addr_i[ADDR_W-1:4] == {TAG_W{1'b1}}) && idx[3];
  assign wr     = cs_i && we_i && in_win;
  assign load   = wr && (idx == IX_CTL) && ctl_w_q && !wdata_i[7];

  rtc_prescaler #(.DIV(TICKS_PER_SEC)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (!osc_stop_q),
    .clr_i  (load),
    .sec_o  (sec_pulse)
  );

  rtc_calendar i_cal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (sec_pulse),
    .load_i     (load),
    .load_val_i (ext_q),
    .cnt_o      (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_w_q    <= 1'b0;
      ctl_r_q    <= 1'b0;
      osc_stop_q <= 1'b1;
      ft_q       <= 1'b0;
    end else if (wr) begin
      if (idx == IX_CTL) begin
        ctl_w_q <= wdata_i[7];
        ctl_r_q <= wdata_i[6];
      end
      if (idx == IX_SEC) osc_stop_q <= wdata_i[7];
      if (idx == IX_DAY) ft_q       <= wdata_i[6];
    end
  end

  // external copy: host-loaded under W, frozen under R, else trails counters
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q <= RESET_TIME;
    end else if (ctl_w_q) begin
      if (wr) begin
        case (idx)
          IX_SEC:  ext_q.sec  <= {1'b0, wdata_i[6:0]};
          IX_MIN:  ext_q.min  <= {1'b0, wdata_i[6:0]};
          IX_HR:   ext_q.hr   <= {2'b0, wdata_i[5:0]};
          IX_DAY:  ext_q.day  <= {5'b0, wdata_i[2:0]};
          IX_DATE: ext_q.date <= {2'b0, wdata_i[5:0]};
          IX_MON:  ext_q.mon  <= {3'b0, wdata_i[4:0]};
          IX_YR:   ext_q.yr   <= wdata_i;
          default: ;
        endcase
      end
    end else if (!ctl_r_q) begin
      ext_q <= cnt;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (cs_i && !we_i && in_win) begin
      case (idx)
        IX_CTL:  rdata_o = {ctl_w_q, ctl_r_q, 6'b0};
        IX_SEC:  rdata_o = {osc_stop_q, ext_q.sec[6:0]};
        IX_MIN:  rdata_o = ext_q.min;
        IX_HR:   rdata_o = ext_q.hr;
        IX_DAY:  rdata_o = {1'b0, ft_q, 3'b0, ext_q.day[2:0]};
        IX_DATE: rdata_o = ext_q.date;
        IX_MON:  rdata_o = ext_q.mon;
        IX_YR:   rdata_o = ext_q.yr;
        default: rdata_o = 8'h00;
      endcase
    end
  end

  AST_STOP_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_stop_q && !load) |=> $stable(cnt)); // R7
  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_r_q && !ctl_w_q) |=> $stable(ext_q)); // R8
  AST_LOAD_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> cnt == $past(ext_q)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && !we_i) |-> rdata_o == 8'h00); // R11
endmodule

// File: tb/test_bcd_rtc.sv
module test_bcd_rtc;
  localparam int unsigned DIV = 4;
  localparam logic [12:0] A_CTL = 13'h1FF8, A_SEC = 13'h1FF9, A_MIN = 13'h1FFA,
                          A_HR = 13'h1FFB, A_DAY = 13'h1FFC, A_DATE = 13'h1FFD,
                          A_MON = 13'h1FFE, A_YR = 13'h1FFF;

  // {start, expected one second later}; fields yr,mon,date,day,hr,min,sec
  localparam logic [111:0] VEC [0:9] = '{
    {56'h01_02_28_03_23_59_59, 56'h01_03_01_04_00_00_00},  // R4 Feb non-leap
    {56'h04_02_28_07_23_59_59, 56'h04_02_29_01_00_00_00},  // R5 leap, day wrap R3
    {56'h00_02_29_02_23_59_59, 56'h00_03_01_03_00_00_00},  // R5 year 00
    {56'h23_04_30_05_23_59_59, 56'h23_05_01_06_00_00_00},  // R4 30-day
    {56'h23_01_30_01_23_59_59, 56'h23_01_31_02_00_00_00},  // R4 31-day
    {56'h99_12_31_06_23_59_59, 56'h00_01_01_07_00_00_00},  // R6
    {56'h10_06_15_01_12_34_59, 56'h10_06_15_01_12_35_00},  // R3
    {56'h10_06_15_01_09_59_59, 56'h10_06_15_01_10_00_00},  // R3
    {56'h21_09_30_04_23_59_59, 56'h21_10_01_05_00_00_00},  // R4
    {56'h21_07_31_04_23_59_59, 56'h21_08_01_05_00_00_00}   // R4
  };

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, cs = 1'b0, we = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_rtc #(.ADDR_W(13), .TICKS_PER_SEC(DIV)) i_bcd_rtc (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .cs_i(cs), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic load_time(input logic [55:0] t);
    wr(A_CTL, 8'h80);
    wr(A_SEC, {1'b0, t[6:0]});
    wr(A_MIN, t[15:8]);
    wr(A_HR, t[23:16]);
    wr(A_DAY, t[31:24]);
    wr(A_DATE, t[39:32]);
    wr(A_MON, t[47:40]);
    wr(A_YR, t[55:48]);
    wr(A_CTL, 8'h00);
  endtask

  task automatic rd_time(output logic [55:0] t);
    logic [7:0] b;
    rd(A_SEC, b);  t[7:0]   = b;
    rd(A_MIN, b);  t[15:8]  = b;
    rd(A_HR, b);   t[23:16] = b;
    rd(A_DAY, b);  t[31:24] = b;
    rd(A_DATE, b); t[39:32] = b;
    rd(A_MON, b);  t[47:40] = b;
    rd(A_YR, b);   t[55:48] = b;
  endtask

  initial begin
    logic [7:0]  b;
    logic [55:0] t;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    rd_time(t); chk(t, 56'h00_01_01_01_00_00_80, "R1 reset time");
    rd(A_CTL, b); chk(b, 8'h00, "R1 reset control");

    ticks(2 * DIV); rd(A_SEC, b); chk(b, 8'h80, "R7 stopped clock holds");
    wr(A_MIN, 8'h30); rd(A_MIN, b); chk(b, 8'h00, "R9 write without load bit ignored");
    wr(A_SEC, 8'h00); rd(A_SEC, b); chk(b, 8'h00, "R7 stop bit cleared");
    ticks(DIV - 1); rd(A_SEC, b); chk(b, 8'h00, "R2 no advance before last tick");
    ticks(1); rd(A_SEC, b); chk(b, 8'h01, "R2 advance on last tick");

    wr(13'h0FF9, 8'h80); ticks(DIV); rd(A_SEC, b); chk(b, 8'h02, "R11 alias outside window ignored");
    wr(13'h1FF3, 8'h55); rd(13'h1FF3, b); chk(b, 8'h00, "R11 low offsets read zero");
    rd(13'h0005, b); chk(b, 8'h00, "R11 outside window reads zero");
    @(negedge clk); cs = 1'b0; addr = A_DAY; #1 chk(rdata, 8'h00, "R11 no data without select");

    wr(A_DAY, 8'h47); rd(A_DAY, b); chk(b, 8'h41, "R10 test bit set, day unchanged");
    wr(A_DAY, 8'h00); rd(A_DAY, b); chk(b, 8'h01, "R10 test bit cleared");

    for (int k = 0; k < 10; k++) begin
      load_time(VEC[k][111:56]);
      ticks(DIV - 1); rd(A_SEC, b);
      chk(b, {1'b0, VEC[k][62:56]}, "R9 tick count restarted on load");
      ticks(1); rd_time(t);
      chk(t, VEC[k][55:0], $sformatf("R3 R4 R5 R6 rollover vector %0d", k));
    end

    load_time(56'h10_06_15_01_00_00_10);
    wr(A_CTL, 8'h40); ticks(DIV);
    rd(A_SEC, b); chk(b, 8'h10, "R8 external frozen under hold");
    rd(A_CTL, b); chk(b, 8'h40, "R8 hold bit reads back");
    wr(A_CTL, 8'h00); rd(A_SEC, b); chk(b, 8'h11, "R8 count ran during hold");

    wr(A_CTL, 8'h80); ticks(DIV); rd(A_SEC, b); chk(b, 8'h11, "R9 external held under load bit");
    wr(A_SEC, 8'h45); rd(A_SEC, b); chk(b, 8'h45, "R9 write lands in external copy");
    wr(A_CTL, 8'h00); rd(A_SEC, b); chk(b, 8'h45, "R9 value loaded on clear");
    ticks(DIV - 1); rd(A_SEC, b); chk(b, 8'h45, "R9 full second after load");
    ticks(1); rd(A_SEC, b); chk(b, 8'h46, "R2 advance after load");

    wr(A_SEC, 8'h80); ticks(DIV); rd(A_SEC, b); chk(b, 8'hC6, "R7 stop bit set at run time");

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule